// File: doc/BRIEF.md
# Programmable Square Wave Divider

This block divides its input clock by a programmable 16-bit value and drives a near-symmetric square wave. A single write strobe delivers the division value. On the clock edge after the write the internal counter takes its start value. From then on the counter steps down by two on every enabled clock. Each time it runs out, the output changes phase and the counter starts again from the same value. This repeats until the next write.

An even value N gives equal high and low halves of N/2 clocks each. An odd value N gives a high half of (N+1)/2 clocks and a low half of (N-1)/2 clocks. To do this, the counter holds its expired state for one extra clock at the end of the high half only. A gate input freezes the counter and the output while it is low. A value of zero stands for 65536. A value of one cannot be divided, so it leaves the output parked high.

Top module: `sqw_divider`

## Requirements
- R1: After reset the output is high and stays high, whatever the gate does, until a value is written.
- R2: The edge that samples `wr_en` drives the output high. The next edge loads the counter, and that load edge takes no count even if the gate is low. The first half-period is then counted on the gated clock edges that follow.
- R3: For an even value N (N >= 2), the output is high for N/2 counted edges and low for N/2 counted edges. This repeats without end, and the internal count falls by exactly two on every counted edge that does not end a half-period.
- R4: For an odd value N (N >= 3), the output is high for (N+1)/2 counted edges and low for (N-1)/2 counted edges, repeating. The internal count always stays even, and the output never changes in the middle of a half-period.
- R5: While `gate_en` is low, the output and the counter hold their values. Each low-gate edge lengthens the current half-period by one clock.
- R6: A written value of 0 acts as 65536, which gives high and low halves of 32768 counted edges.
- R7: A written value of 1 is illegal. The output goes high and stays high until the next write.
- R8: A write while running abandons the current period. The output is high from the write edge on, and the new value is loaded on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_en | input | 1 | High lets the counter step; low freezes the count and the output |
| wr_en | input | 1 | One-cycle strobe that writes a new division value |
| wr_count | input | 16 | Division value; 0 means 65536, 1 is illegal |
| wave_out | output | 1 | Square wave output |

## Verification
Small even and odd values are run with the gate held high. These runs separate the equal-halves case from the longer-high case, and N=2 and N=3 expose any off-by-one at the shortest periods. Random gate dips during a run show whether a frozen edge lengthens the phase or silently drops a count. A full 65536 period and a parked value of one test the two encoding ends. Random rewrites at arbitrary points in a period show whether the restart and the unconditional load edge land on the right clock.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  // Loader sequencing: idle until written, one arming edge, then running.
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_ARM  = 2'd1,
    LD_RUN  = 2'd2,
    LD_BAD  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/sqw_rst_sync.sv
module sqw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sqw_loader.sv
module sqw_loader
  import sqw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  output logic             load_stb,
  output logic             run_en,
  output logic             illegal,
  output logic             odd_cnt,
  output logic [CNT_W:0]   reload_val
);
  localparam logic [CNT_W-1:0] ONE_VAL  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W:0]   FULL_VAL = {1'b1, {CNT_W{1'b0}}};

  ld_state_e        state_q, state_d;
  logic [CNT_W:0]   reload_q, reload_d;
  logic             odd_q, odd_d;
  logic             ld_en;

  // Even start value: zero means full range, odd values drop their LSB.
  always_comb begin
    state_d  = state_q;
    reload_d = reload_q;
    odd_d    = odd_q;
    if (wr_en) begin
      if (wr_count == '0) reload_d = FULL_VAL;
      else                reload_d = {1'b0, wr_count[CNT_W-1:1], 1'b0};
      odd_d   = wr_count[0];
      state_d = (wr_count == ONE_VAL) ? LD_BAD : LD_ARM;
    end else if (state_q == LD_ARM) begin
      state_d = LD_RUN;
    end
  end

  assign ld_en = wr_en | (state_q == LD_ARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LD_IDLE;
      reload_q <= '0;
      odd_q    <= 1'b0;
    end else if (ld_en) begin
      state_q  <= state_d;
      reload_q <= reload_d;
      odd_q    <= odd_d;
    end
  end

  assign load_stb   = (state_q == LD_ARM);
  assign run_en     = (state_q == LD_RUN);
  assign illegal    = (state_q == LD_BAD);
  assign odd_cnt    = odd_q;
  assign reload_val = reload_q;
endmodule

// File: rtl/sqw_downcnt.sv
module sqw_downcnt #(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_stb,
  input  logic           step,
  input  logic           reload_now,
  input  logic [CNT_W:0] reload_val,
  output logic [CNT_W:0] cnt,
  output logic           cnt_is2,
  output logic           cnt_is0
);
  localparam logic [CNT_W:0] TWO = {{(CNT_W-1){1'b0}}, 2'b10};

  logic [CNT_W:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    if (load_stb || reload_now) cnt_d = reload_val;
    else                        cnt_d = cnt_q - TWO;
  end

  assign cnt_en = load_stb | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign cnt_is2 = (cnt_q == TWO);
  assign cnt_is0 = (cnt_q == '0);
endmodule

// File: rtl/sqw_phase.sv
module sqw_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic load_stb,
  input  logic step,
  input  logic odd_cnt,
  input  logic cnt_is2,
  input  logic cnt_is0,
  output logic reload_now,
  output logic wave
);
  logic wave_q, wave_d;
  logic expire, hold_extra, wave_en;

  // Odd values spend one extra edge at zero before the high half ends.
  assign expire     = step & cnt_is2;
  assign hold_extra = odd_cnt & wave_q;
  assign reload_now = (expire & ~hold_extra) | (step & cnt_is0);

  always_comb begin
    wave_d = wave_q;
    if (wr_en || load_stb)       wave_d = 1'b1;
    else if (step && cnt_is0)    wave_d = 1'b0;
    else if (expire && !hold_extra) wave_d = ~wave_q;
  end

  assign wave_en = wr_en | load_stb | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wave_q <= 1'b1;
    else if (wave_en) wave_q <= wave_d;
  end

  assign wave = wave_q;
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  output logic             wave_out
);
  logic           rst_n_int;
  logic           load_stb, run_en, illegal, odd_cnt;
  logic [CNT_W:0] reload_val, cnt;
  logic           cnt_is2, cnt_is0, reload_now, step;

  sqw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sqw_loader #(.CNT_W(CNT_W)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (wr_en),
    .wr_count   (wr_count),
    .load_stb   (load_stb),
    .run_en     (run_en),
    .illegal    (illegal),
    .odd_cnt    (odd_cnt),
    .reload_val (reload_val)
  );

  assign step = run_en & gate_en & ~wr_en;

  sqw_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_stb   (load_stb),
    .step       (step),
    .reload_now (reload_now),
    .reload_val (reload_val),
    .cnt        (cnt),
    .cnt_is2    (cnt_is2),
    .cnt_is0    (cnt_is0)
  );

  sqw_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (wr_en),
    .load_stb   (load_stb),
    .step       (step),
    .odd_cnt    (odd_cnt),
    .cnt_is2    (cnt_is2),
    .cnt_is0    (cnt_is0),
    .reload_now (reload_now),
    .wave       (wave_out)
  );
endmodule

// File: rtl/sqw_divider_chk.sv
module sqw_divider_chk #(
  parameter int CNT_W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gate_en,
  input logic           wr_en,
  input logic           wave_out,
  input logic           run_en,
  input logic           illegal,
  input logic [CNT_W:0] cnt
);
  localparam logic [CNT_W:0] TWO = {{(CNT_W-1){1'b0}}, 2'b10};

  AST_WR_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wave_out); // R2

  AST_STEP_BY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && gate_en && !wr_en && cnt > TWO) |=> (cnt == $past(cnt) - TWO)); // R3

  AST_MID_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && gate_en && !wr_en && cnt > TWO) |=> $stable(wave_out)); // R4

  AST_COUNT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> !cnt[0]); // R4

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !gate_en && !wr_en) |=> ($stable(wave_out) && $stable(cnt))); // R5

  AST_ILLEGAL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> wave_out); // R7
endmodule

bind sqw_divider sqw_divider_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_en  (gate_en),
  .wr_en    (wr_en),
  .wave_out (wave_out),
  .run_en   (run_en),
  .illegal  (illegal),
  .cnt      (cnt)
);

// File: tb/sqw_divider_test.sv
module sqw_divider_test;
  logic        clk;
  logic        rst_n;
  logic        gate_en;
  logic        wr_en;
  logic [15:0] wr_count;
  logic        wave_out;

  int runs;
  int fails;

  // Abstract phase model: counted edges remaining in the current half.
  logic        exp_w;
  logic        pend;
  logic        legal;
  logic        active;
  int          left;
  int          cur_n;

  sqw_divider uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_en  (gate_en),
    .wr_en    (wr_en),
    .wr_count (wr_count),
    .wave_out (wave_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int hi_len(input int n);
    return (n % 2 == 1) ? (n + 1) / 2 : n / 2;
  endfunction

  function automatic int lo_len(input int n);
    return (n % 2 == 1) ? (n - 1) / 2 : n / 2;
  endfunction

  task automatic check(input string tag);
    runs++;
    if (wave_out !== exp_w) begin
      fails++;
      $display("FAIL %s: wave_out=%b expected %b at %0t", tag, wave_out, exp_w, $time);
    end
  endtask

  // One cycle: check the state left by the previous edge, then drive the
  // inputs for the next edge and advance the model across it.
  task automatic cyc(input logic wr, input logic [15:0] c, input logic g,
                     input string tag);
    @(negedge clk);
    check(tag);
    wr_en    = wr;
    wr_count = c;
    gate_en  = g;
    if (wr) begin
      exp_w  = 1'b1;
      pend   = 1'b1;
      cur_n  = (c == 16'd0) ? 65536 : int'(c);
      legal  = (c != 16'd1);
      active = 1'b0;
    end else if (pend) begin
      pend = 1'b0;
      if (legal) begin
        active = 1'b1;
        left   = hi_len(cur_n);
      end
    end else if (active && g) begin
      left--;
      if (left == 0) begin
        exp_w = ~exp_w;
        left  = exp_w ? hi_len(cur_n) : lo_len(cur_n);
      end
    end
  endtask

  task automatic run_fixed(input logic [15:0] n, input int cycles, input string tag);
    cyc(1'b1, n, 1'b1, tag);
    for (int i = 0; i < cycles; i++) cyc(1'b0, 16'd0, 1'b1, tag);
  endtask

  initial begin
    int seed_v;
    runs = 0; fails = 0;
    seed_v = $urandom(32'd2718);
    exp_w = 1'b1; pend = 1'b0; legal = 1'b0; active = 1'b0; left = 0; cur_n = 0;
    gate_en = 1'b0; wr_en = 1'b0; wr_count = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    runs++;
    if (wave_out !== 1'b1) begin
      fails++;
      $display("FAIL R1: wave_out=%b expected 1 in reset", wave_out);
    end
    rst_n = 1'b1;
    // R1: idle after reset, gate toggling has no effect
    for (int i = 0; i < 20; i++) cyc(1'b0, 16'd0, i[0], "R1");

    // R3: even values, gate high
    run_fixed(16'd2, 12, "R3");
    run_fixed(16'd4, 20, "R3");
    run_fixed(16'd10, 45, "R3");
    // R4: odd values, gate high
    run_fixed(16'd3, 15, "R4");
    run_fixed(16'd5, 25, "R4");
    run_fixed(16'd7, 40, "R4");
    // R2: load edge ignores a low gate
    cyc(1'b1, 16'd6, 1'b1, "R2");
    cyc(1'b0, 16'd0, 1'b0, "R2");
    for (int i = 0; i < 20; i++) cyc(1'b0, 16'd0, 1'b1, "R2");
    // R5: random gate dips during odd and even runs
    cyc(1'b1, 16'd9, 1'b1, "R5");
    for (int i = 0; i < 200; i++) cyc(1'b0, 16'd0, ($urandom % 4) != 0, "R5");
    cyc(1'b1, 16'd8, 1'b1, "R5");
    for (int i = 0; i < 200; i++) cyc(1'b0, 16'd0, ($urandom % 3) != 0, "R5");
    // R7: value one parks the output high
    run_fixed(16'd1, 100, "R7");
    // R8: rewrite in the middle of a period
    run_fixed(16'd20, 15, "R8");
    run_fixed(16'd6, 30, "R8");
    run_fixed(16'd11, 3, "R8");
    run_fixed(16'd4, 20, "R8");
    // R6: zero means 65536, one full period and a bit
    run_fixed(16'd0, 65536 + 200, "R6");
    // R2: random values, random gate, random rewrite points
    for (int s = 0; s < 40; s++) begin
      logic [15:0] n;
      int len;
      n   = 16'(($urandom % 60) + 1);
      len = 50 + int'($urandom % 250);
      cyc(1'b1, n, ($urandom % 2) == 0, "R2");
      for (int i = 0; i < len; i++) cyc(1'b0, 16'd0, ($urandom % 5) != 0, "R2");
    end
    cyc(1'b0, 16'd0, 1'b1, "R2");

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule